// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for each beat of a four-beat memory burst. Asserting either of two address strobes captures a full start address and the burst-order choice in the same clock edge. After that, the two least significant address bits step through a four-beat sequence, one step per cycle in which the advance input is high. The upper address bits stay at the captured value.

Two orders are supported. Linear order adds the beat count to the start offset modulo four. Interleaved order XORs the start offset with the beat count. Interleaved is the order used when the order input is held low, which is its tie-off value. A new address can be captured on any cycle, so a caller may treat the block as a plain address register and never advance it.

The controller is a five-state machine. `S_IDLE` is the state after reset, before any capture. `S_BEAT0`, `S_BEAT1`, `S_BEAT2` and `S_BEAT3` each mean that the named beat of the current burst is on the output. The transitions are:

- Load: a strobe moves the machine from any state to `S_BEAT0`.
- Step: advance without a strobe moves `S_BEATk` to `S_BEAT(k+1)`.
- Wrap: advance in `S_BEAT3` without a strobe moves the machine to `S_BEAT0`.
- Hold: with neither a strobe nor advance, the machine stays where it is. In `S_IDLE` the machine also stays put when advance is high.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset `addr_out` is 0 and `burst_active` is 0, and the captured order is interleaved.
- R2: When `strobe_a` is high at a rising edge, then after that edge `addr_out` equals the `addr_in` sampled at that edge and `burst_active` is 1.
- R3: When `strobe_b` is high at a rising edge, it captures `addr_in` in the same way as `strobe_a`.
- R4: A capture takes priority over advance. When either strobe or both strobes are high together with `advance`, the output after the edge is the new `addr_in` at beat 0.
- R5: With `order_linear`=1 sampled at capture, the low two bits after k advances are (start + k) mod 4. For example, a start of 1 gives 1, 2, 3, 0.
- R6: With `order_linear`=0 sampled at capture, the low two bits after k advances are start XOR (k mod 4). For example, a start of 1 gives 1, 0, 3, 2.
- R7: On a cycle where neither strobe nor `advance` is high, `addr_out` and `burst_active` keep their values.
- R8: The fourth advance returns the low bits to the start value. Bits above bit 1 never change without a capture, so there is no carry out of the 2-bit field.
- R9: `order_linear` is sampled only at a capture. Changing it during a burst has no effect on the sequence.
- R10: Before the first capture after reset, `advance` has no effect: `addr_out` stays 0 and `burst_active` stays 0.
- R11: A capture on every consecutive cycle puts each new address on `addr_out` one cycle later, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_a | input | 1 | First address strobe: captures `addr_in` and starts a burst |
| strobe_b | input | 1 | Second address strobe, same effect as `strobe_a` |
| advance | input | 1 | Steps to the next beat when no strobe is high |
| order_linear | input | 1 | 1 = linear order, 0 = interleaved order (tie-off default); sampled at capture |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current beat address |
| burst_active | output | 1 | High once a burst has been captured |

## Verification
The bench builds the block with `ADDR_W` = 12. With that width, random start addresses produce many distinct upper-bit patterns across all four start offsets, so a carry out of the 2-bit field shows up as a wrong upper bit after a wrap. The narrow width also makes repeated and neighbouring addresses likely. Those make back-to-back captures of the same or nearby values a real test of R11 and R4.

// File: rtl/bag_pkg.sv
package bag_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_BEAT0 = 3'd1,
        S_BEAT1 = 3'd2,
        S_BEAT2 = 3'd3,
        S_BEAT3 = 3'd4
    } bag_state_t;

    typedef enum logic {
        ORD_ILV = 1'b0,
        ORD_LIN = 1'b1
    } bag_order_t;

    // Low-order offset for beat k given the start offset and the order.
    function automatic logic [BEAT_W-1:0] beat_offset(
        input bag_order_t        ord,
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] k
    );
        if (ord == ORD_LIN) return start + k;
        else                return start ^ k;
    endfunction

endpackage

// File: rtl/bag_fsm.sv
module bag_fsm
    import bag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    output bag_state_t        state,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              active
);

    bag_state_t state_q, state_d;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = S_BEAT0;
        end else if (advance) begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_BEAT0: state_d = S_BEAT1;
                S_BEAT1: state_d = S_BEAT2;
                S_BEAT2: state_d = S_BEAT3;
                S_BEAT3: state_d = S_BEAT0;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs decoded from state
    always_comb begin
        beat_idx = '0;
        active   = 1'b1;
        unique case (state_q)
            S_IDLE:  begin beat_idx = 2'd0; active = 1'b0; end
            S_BEAT0: beat_idx = 2'd0;
            S_BEAT1: beat_idx = 2'd1;
            S_BEAT2: beat_idx = 2'd2;
            S_BEAT3: beat_idx = 2'd3;
            default: begin beat_idx = 2'd0; active = 1'b0; end
        endcase
    end

    assign state = state_q;

    assert_wrap_to_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BEAT3 && advance && !load) |=> (state_q == S_BEAT0));

    assert_idle_ignores_adv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !load) |=> (state_q == S_IDLE));

    assert_load_to_beat0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == S_BEAT0));

endmodule

// File: rtl/bag_capture.sv
module bag_capture
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_in,
    output logic [ADDR_W-1:0] base_q,
    output bag_order_t        order_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            order_q <= ORD_ILV;
        end else if (load) begin
            base_q  <= addr_in;
            order_q <= order_in ? ORD_LIN : ORD_ILV;
        end
    end

    assert_base_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(base_q));

    assert_order_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(order_q));

endmodule

// File: rtl/bag_addr_mux.sv
module bag_addr_mux
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  bag_order_t        order,
    input  logic [BEAT_W-1:0] beat_idx,
    output logic [ADDR_W-1:0] addr
);

    logic [BEAT_W-1:0] low;

    assign low = beat_offset(order, base[BEAT_W-1:0], beat_idx);

    generate
        if (ADDR_W > BEAT_W) begin : g_upper
            assign addr = {base[ADDR_W-1:BEAT_W], low};
        end else begin : g_narrow
            assign addr = low;
        end
    endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_a,
    input  logic              strobe_b,
    input  logic              advance,
    input  logic              order_linear,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_active
);

    logic              load;
    bag_state_t        state;
    logic [BEAT_W-1:0] beat_idx;
    logic [ADDR_W-1:0] base_q;
    bag_order_t        order_q;

    assign load = strobe_a | strobe_b;

    bag_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .state    (state),
        .beat_idx (beat_idx),
        .active   (burst_active)
    );

    bag_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .addr_in  (addr_in),
        .order_in (order_linear),
        .base_q   (base_q),
        .order_q  (order_q)
    );

    bag_addr_mux #(.ADDR_W(ADDR_W)) u_mux (
        .base     (base_q),
        .order    (order_q),
        .beat_idx (beat_idx),
        .addr     (addr_out)
    );

    assert_strobe_a_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_a |=> (addr_out == $past(addr_in) && burst_active));

    assert_strobe_b_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_b |=> (addr_out == $past(addr_in) && burst_active));

    assert_load_beats_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && advance) |=> (addr_out == $past(addr_in)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance) |=> ($stable(addr_out) && $stable(burst_active)));

    assert_idle_default_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |-> (order_q == ORD_ILV && addr_out == '0));

    assert_active_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active |=> burst_active);

    assert_state_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {S_IDLE, S_BEAT0, S_BEAT1, S_BEAT2, S_BEAT3});

endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          strobe_a, strobe_b, advance, order_linear;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic          burst_active;

    int tests  = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference state
    logic [AW-1:0] m_base;
    logic [1:0]    m_k;
    logic          m_lin;
    logic          m_active;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_a     (strobe_a),
        .strobe_b     (strobe_b),
        .advance      (advance),
        .order_linear (order_linear),
        .addr_in      (addr_in),
        .addr_out     (addr_out),
        .burst_active (burst_active)
    );

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] k, logic lin);
        logic [1:0] lo;
        lo = lin ? (b[1:0] + k) : (b[1:0] ^ k);
        return {b[AW-1:2], lo};
    endfunction

    task automatic check(string tag, logic [AW-1:0] exp_a, logic exp_act);
        tests++;
        if (addr_out !== exp_a || burst_active !== exp_act) begin
            fails++;
            $display("FAIL %s: addr_out=%h active=%b expected addr_out=%h active=%b",
                     tag, addr_out, burst_active, exp_a, exp_act);
        end
    endtask

    // Drive inputs at negedge, let one posedge pass, check at next negedge.
    task automatic step(logic a, logic b, logic adv, logic lin, logic [AW-1:0] ad, string tag);
        strobe_a = a; strobe_b = b; advance = adv; order_linear = lin; addr_in = ad;
        @(posedge clk);
        if (a || b) begin
            m_base = ad; m_k = 2'd0; m_lin = lin; m_active = 1'b1;
        end else if (adv && m_active) begin
            m_k = m_k + 2'd1;
        end
        @(negedge clk);
        check(tag, m_active ? exp_addr(m_base, m_k, m_lin) : '0, m_active);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; strobe_a = 0; strobe_b = 0; advance = 0; order_linear = 0; addr_in = '0;
        m_base = '0; m_k = '0; m_lin = 1'b0; m_active = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", '0, 1'b0);

        // R10: advance before any capture
        step(0, 0, 1, 1, 12'h5A5, "R10 idle advance");
        step(0, 0, 1, 0, 12'h123, "R10 idle advance");

        // R2 + R5: linear from offset 1 -> 1,2,3,0 then wrap R8
        step(1, 0, 0, 1, 12'hAB1, "R2 strobe_a load");
        step(0, 0, 1, 1, '0, "R5 linear beat1");
        tests++; if (addr_out !== 12'hAB2) begin fails++; $display("FAIL R5: addr_out=%h expected=%h", addr_out, 12'hAB2); end
        step(0, 0, 1, 1, '0, "R5 linear beat2");
        step(0, 0, 1, 1, '0, "R5 linear beat3");
        tests++; if (addr_out !== 12'hAB0) begin fails++; $display("FAIL R8: no-carry addr_out=%h expected=%h", addr_out, 12'hAB0); end
        step(0, 0, 1, 1, '0, "R8 wrap to start");
        step(0, 0, 0, 1, '0, "R7 hold");
        step(0, 0, 0, 0, '0, "R7 hold");

        // R3 + R6: interleaved from offset 1 -> 1,0,3,2; R9 order change ignored
        step(0, 1, 0, 0, 12'h7F1, "R3 strobe_b load");
        step(0, 0, 1, 1, '0, "R9 order change mid-burst");
        tests++; if (addr_out !== 12'h7F0) begin fails++; $display("FAIL R6: addr_out=%h expected=%h", addr_out, 12'h7F0); end
        step(0, 0, 1, 1, '0, "R6 interleaved beat2");
        step(0, 0, 1, 0, '0, "R6 interleaved beat3");
        tests++; if (addr_out !== 12'h7F2) begin fails++; $display("FAIL R6: addr_out=%h expected=%h", addr_out, 12'h7F2); end
        step(0, 0, 1, 0, '0, "R8 wrap interleaved");

        // R4: both strobes plus advance
        step(0, 0, 1, 0, '0, "R6 advance");
        step(1, 1, 1, 1, 12'hFFF, "R4 load over advance");
        step(1, 0, 1, 0, 12'hFFE, "R4 load over advance");
        step(0, 0, 1, 0, '0, "R8 top offset no carry");

        // R11: capture every cycle
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a;
            a = AW'(i * 12'h1C3 + 5);
            step(i[0], ~i[0], 0, i[1], a, "R11 back-to-back load");
        end

        // Random stimulus
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic sa, sb, adv;
            r   = $urandom_range(0, 99);
            sa  = (r < 12);
            sb  = (r >= 8 && r < 20);
            adv = ($urandom_range(0, 3) != 0);
            step(sa, sb, adv, 1'($urandom_range(0, 1)), AW'($urandom),
                 (sa || sb) ? (adv ? "R4 random" : "R2 R3 random") :
                 (adv ? "R5 R6 R8 random" : "R7 random"));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule